// File: doc/BRIEF.md
# Misaligned Operand Cache-Fill Sequencer

This block sits in a processor's data fetch path between the load unit and the external bus. It accepts a 32-bit operand read at any byte address and runs the external bus cycles needed to collect the four operand bytes. It also captures every byte of each aligned long-word cache entry that the operand touches. An operand at a byte offset other than zero spans two entries. Every fill strobe therefore carries a complete long word, ready to be written into the data cache.

The responding port reports its width when it terminates each cycle. It does this with a 16-bit acknowledge, a 32-bit acknowledge, or a synchronous 32-bit termination. The sequencer picks its next cycle from that sample alone. On a narrow port it works entry by entry. Within an entry it first reads the words that hold operand bytes, then reads back the remaining word. A misaligned read at `$06` therefore produces the non-monotonic order `$06`, `$04`, `$08`, `$0A`. On a wide port the same read takes two long-word cycles.

The assembled operand is presented with a one-cycle valid pulse. Each finished entry is presented with a one-cycle write strobe, its aligned address and its data. A busy flag covers the whole sequence, and requests are refused while it is set.

Top module: `ofs_fill_seq`

## Requirements
- R1: The clock edge that accepts a request (req_valid high while busy is low) starts the first bus cycle: bus_cyc goes high with bus_addr equal to the request address and bus_size = 2'b00 (four bytes).
- R2: When every cycle ends with the 32-bit acknowledge, a read at byte offset 1, 2 or 3 takes exactly two cycles. The first is at the operand address and the second is at the next aligned long word, both with bus_size = 2'b00.
- R3: A cycle ended by the synchronous 32-bit termination (sterm) behaves exactly as one ended by the 32-bit acknowledge. It captures the whole aligned long word and follows the same two-cycle order.
- R4: On a 16-bit port a misaligned read with entry base E visits E+o, then E (offset 2 or 3) or E+2 (offset 1), then E+4, then E+6. Every cycle after the first uses bus_size = 2'b10 (two bytes) at an even address.
- R5: An aligned read completes in one cycle on a 32-bit port, and in two ascending word cycles (E, then E+2) on a 16-bit port.
- R6: Byte lanes are big-endian. On a 16-bit port, the byte at the even word address is on bus_rdata[31:24] and the next byte is on [23:16], with [15:0] ignored. On a 32-bit port, the byte at the aligned address is on [31:24] and the following bytes are on the lower lanes in order.
- R7: op_valid pulses for exactly one cycle per request. It goes high in the cycle after the termination that captures the last operand byte, and op_data then holds the byte at the operand address on [31:24], followed by the next three bytes.
- R8: Each entry that the operand touches gets exactly one fill_we pulse, in ascending address order, in the cycle after its fourth byte is captured. The pulse carries the aligned fill_addr and the big-endian fill_data for that entry.
- R9: busy rises with the first bus cycle and falls in the cycle after the final termination. A request presented while busy is ignored, and no cycle follows the last one.
- R10: Port width is sampled on every termination, and mixed widths within one sequence are handled. After a 32-bit termination the next cycle asks for four bytes at the aligned entry address. If both acknowledges arrive together, the 32-bit one takes precedence.
- R11: bus_addr, bus_size and bus_cyc stay steady while a cycle waits for its termination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operand read request |
| req_addr | input | ADDR_W | Operand byte address |
| busy | output | 1 | Sequence in progress |
| bus_cyc | output | 1 | External bus cycle active |
| bus_addr | output | ADDR_W | Address of the current bus cycle |
| bus_size | output | 2 | Bytes requested: 00 = four, 10 = two |
| ack16 | input | 1 | Cycle ended, 16-bit port |
| ack32 | input | 1 | Cycle ended, 32-bit port |
| sterm | input | 1 | Synchronous 32-bit termination |
| bus_rdata | input | 32 | Read data from the bus |
| op_valid | output | 1 | Operand assembled (one-cycle pulse) |
| op_data | output | 32 | Assembled operand, big-endian |
| fill_we | output | 1 | Cache entry write strobe |
| fill_addr | output | ADDR_W | Aligned address of the entry |
| fill_data | output | 32 | Entry data, big-endian |

## Verification
Every byte offset is run against each termination pattern: pure 16-bit acknowledges, pure 32-bit acknowledges, pure synchronous terminations, alternating 16/32 widths, and both acknowledges together. Each run is repeated at several base addresses, with wait states that alternate between zero and one. The pure-width runs separate the narrow entry-by-entry order from the two-cycle wide order, and the offset sweep separates the three misaligned reorderings from the aligned case. The alternating runs show that the size of the next request follows the last sampled width. The dual-acknowledge run shows the precedence of the wide width. The memory model puts filler on the unused lower half in 16-bit responses, so any lane mis-steering shows up in the assembled operand, the fill data and the timing of the pulses.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;
  localparam int BUS_W      = 32;
  localparam int ENT_BYTES  = BUS_W / 8;
  localparam int SPAN_BYTES = 2 * ENT_BYTES;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b10
  } siz_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } st_e;

  // Big-endian pick of four consecutive bytes starting at slot 'first'
  function automatic logic [BUS_W-1:0] pack_be(
    input logic [SPAN_BYTES*8-1:0] b,
    input int first
  );
    logic [BUS_W-1:0] r;
    for (int k = 0; k < ENT_BYTES; k++) begin
      r[BUS_W-1-8*k -: 8] = b[(first+k)*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/ofs_byte_capture.sv
module ofs_byte_capture
  import ofs_seq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic [SPAN_BYTES-1:0]   clear_mask,
  input  logic                    cap_en,
  input  logic                    cap_wide,
  input  logic                    cap_ent,
  input  logic                    cap_word,
  input  logic [BUS_W-1:0]        rdata,
  output logic [SPAN_BYTES-1:0]   have_q,
  output logic [SPAN_BYTES-1:0]   have_d,
  output logic [SPAN_BYTES*8-1:0] bytes_d
);
  logic [SPAN_BYTES*8-1:0] bytes_q;

  // Steer bus lanes into byte slots: wide port fills a whole entry,
  // narrow port fills one half of it from the upper data lanes.
  always_comb begin
    have_d  = have_q;
    bytes_d = bytes_q;
    if (cap_en) begin
      for (int k = 0; k < ENT_BYTES; k++) begin
        if (cap_wide || ((k / 2) == int'(cap_word))) begin
          have_d[(cap_ent ? ENT_BYTES : 0) + k] = 1'b1;
          bytes_d[((cap_ent ? ENT_BYTES : 0) + k)*8 +: 8] =
            rdata[BUS_W-1-8*(cap_wide ? k : (k % 2)) -: 8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q  <= '0;
      bytes_q <= '0;
    end else if (clear) begin
      have_q  <= clear_mask;
    end else begin
      have_q  <= have_d;
      bytes_q <= bytes_d;
    end
  end
endmodule

// File: rtl/ofs_next_pick.sv
module ofs_next_pick
  import ofs_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [SPAN_BYTES-1:0] have,
  input  logic [SPAN_BYTES-1:0] opm,
  input  logic [ADDR_W-1:0]     base,
  input  logic                  wide_last,
  output logic [ADDR_W-1:0]     nxt_addr,
  output logic [1:0]            nxt_size,
  output logic                  all_done
);
  logic                 ent;
  logic [ENT_BYTES-1:0] eh, eo, miss, gap;
  logic                 wsel;
  logic [ADDR_W-1:0]    ent_base;

  always_comb begin
    ent  = &have[ENT_BYTES-1:0];
    eh   = ent ? have[SPAN_BYTES-1:ENT_BYTES] : have[ENT_BYTES-1:0];
    eo   = ent ? opm[SPAN_BYTES-1:ENT_BYTES]  : opm[ENT_BYTES-1:0];
    miss = eo & ~eh;
    gap  = ~eh;
    // operand words of the entry first, then the remaining word
    if (|miss[1:0])      wsel = 1'b0;
    else if (|miss[3:2]) wsel = 1'b1;
    else if (|gap[1:0])  wsel = 1'b0;
    else                 wsel = 1'b1;
    ent_base = base + (ent ? ADDR_W'(ENT_BYTES) : '0);
    if (wide_last) begin
      nxt_addr = ent_base;
      nxt_size = SZ_LONG;
    end else begin
      nxt_addr = ent_base + ADDR_W'({wsel, 1'b0});
      nxt_size = SZ_WORD;
    end
    all_done = &have;
  end
endmodule

// File: rtl/ofs_fill_seq.sv
module ofs_fill_seq
  import ofs_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              bus_cyc,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  input  logic              ack16,
  input  logic              ack32,
  input  logic              sterm,
  input  logic [31:0]       bus_rdata,
  output logic              op_valid,
  output logic [31:0]       op_data,
  output logic              fill_we,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [31:0]       fill_data
);
  st_e                     state;
  logic [ADDR_W-1:0]       base_q;
  logic [SPAN_BYTES-1:0]   opm_q;
  logic [1:0]              off_q;
  logic                    op_done_q;

  logic                    term, wide, accept, cap_en, cap_ent;
  logic [SPAN_BYTES-1:0]   have_q, have_d, clr_mask;
  logic [SPAN_BYTES*8-1:0] bytes_d;
  logic [ADDR_W-1:0]       nxt_addr;
  logic [1:0]              nxt_size;
  logic                    all_done;

  assign term     = ack16 | ack32 | sterm;
  assign wide     = ack32 | sterm;
  assign accept   = (state == S_IDLE) && req_valid;
  assign cap_en   = (state == S_RUN) && bus_cyc && term;
  assign cap_ent  = bus_addr[ADDR_W-1:2] != base_q[ADDR_W-1:2];
  // an aligned operand never touches the second entry: mark it present
  assign clr_mask = (req_addr[1:0] == 2'b00) ?
                    {{ENT_BYTES{1'b1}}, {ENT_BYTES{1'b0}}} : '0;

  ofs_byte_capture u_cap (
    .clk        (clk),
    .rst        (rst),
    .clear      (accept),
    .clear_mask (clr_mask),
    .cap_en     (cap_en),
    .cap_wide   (wide),
    .cap_ent    (cap_ent),
    .cap_word   (bus_addr[1]),
    .rdata      (bus_rdata),
    .have_q     (have_q),
    .have_d     (have_d),
    .bytes_d    (bytes_d)
  );

  ofs_next_pick #(.ADDR_W(ADDR_W)) u_pick (
    .have      (have_d),
    .opm       (opm_q),
    .base      (base_q),
    .wide_last (wide),
    .nxt_addr  (nxt_addr),
    .nxt_size  (nxt_size),
    .all_done  (all_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      busy      <= 1'b0;
      bus_cyc   <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= SZ_LONG;
      base_q    <= '0;
      opm_q     <= '0;
      off_q     <= '0;
      op_done_q <= 1'b0;
      op_valid  <= 1'b0;
      op_data   <= '0;
      fill_we   <= 1'b0;
      fill_addr <= '0;
      fill_data <= '0;
    end else begin
      op_valid <= 1'b0;
      fill_we  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            state     <= S_RUN;
            busy      <= 1'b1;
            bus_cyc   <= 1'b1;
            bus_addr  <= req_addr;
            bus_size  <= SZ_LONG;
            base_q    <= {req_addr[ADDR_W-1:2], 2'b00};
            opm_q     <= SPAN_BYTES'({ENT_BYTES{1'b1}}) << req_addr[1:0];
            off_q     <= req_addr[1:0];
            op_done_q <= 1'b0;
          end
        end
        S_RUN: begin
          if (term) begin
            if (!op_done_q && ((have_d & opm_q) == opm_q)) begin
              op_valid  <= 1'b1;
              op_data   <= pack_be(bytes_d, int'(off_q));
              op_done_q <= 1'b1;
            end
            if ((&have_d[ENT_BYTES-1:0]) && !(&have_q[ENT_BYTES-1:0])) begin
              fill_we   <= 1'b1;
              fill_addr <= base_q;
              fill_data <= pack_be(bytes_d, 0);
            end else if ((&have_d[SPAN_BYTES-1:ENT_BYTES]) &&
                         !(&have_q[SPAN_BYTES-1:ENT_BYTES])) begin
              fill_we   <= 1'b1;
              fill_addr <= base_q + ADDR_W'(ENT_BYTES);
              fill_data <= pack_be(bytes_d, ENT_BYTES);
            end
            if (all_done) begin
              state   <= S_IDLE;
              busy    <= 1'b0;
              bus_cyc <= 1'b0;
            end else begin
              bus_addr <= nxt_addr;
              bus_size <= nxt_size;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ofs_fill_seq_chk.sv
module ofs_fill_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              bus_cyc,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              ack16,
  input logic              ack32,
  input logic              sterm,
  input logic              op_valid,
  input logic              fill_we,
  input logic [1:0]        fill_lsb
);
  // R9
  cyc_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_cyc |-> busy);

  // R11
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !(ack16 || ack32 || sterm)) |=>
      (bus_cyc && $stable(bus_addr) && $stable(bus_size)));

  // R1
  first_long_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (bus_cyc && bus_size == 2'b00));

  // R7
  op_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !op_valid);

  // R8
  fill_align_chk: assert property (@(posedge clk) disable iff (rst)
    fill_we |-> (fill_lsb == 2'b00));

  // R4
  word_even_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && bus_size == 2'b10) |-> (bus_addr[0] == 1'b0));
endmodule

bind ofs_fill_seq ofs_fill_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .bus_cyc  (bus_cyc),
  .bus_addr (bus_addr),
  .bus_size (bus_size),
  .ack16    (ack16),
  .ack32    (ack32),
  .sterm    (sterm),
  .op_valid (op_valid),
  .fill_we  (fill_we),
  .fill_lsb (fill_addr[1:0])
);

// File: tb/tb_ofs_fill_seq.sv
module tb_ofs_fill_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        busy, bus_cyc, op_valid, fill_we;
  logic [31:0] bus_addr, op_data, fill_addr, fill_data;
  logic [1:0]  bus_size;
  logic        ack16 = 1'b0, ack32 = 1'b0, sterm = 1'b0;
  logic [31:0] bus_rdata = '0;

  ofs_fill_seq #(.ADDR_W(32)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .bus_cyc(bus_cyc), .bus_addr(bus_addr), .bus_size(bus_size),
    .ack16(ack16), .ack32(ack32), .sterm(sterm), .bus_rdata(bus_rdata),
    .op_valid(op_valid), .op_data(op_data),
    .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, tcnt = 0, mode = 0, ncyc = 0, wcnt = 0;
  int nop = 0, nfill = 0, op_t = 0, idle_t = 0;
  logic [31:0] log_addr[8];
  logic [1:0]  log_size[8];
  int          log_t[8];
  logic [31:0] op_got, fa[4], fd[4];
  logic        busy_prev = 1'b0;
  bit          done = 1'b0;

  function automatic logic [7:0] mb(logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [31:0] ml(logic [31:0] a);
    return {mb(a), mb(a + 1), mb(a + 2), mb(a + 3)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) tcnt++;

  // Memory-model responder: mode 0 = 16-bit, 1 = 32-bit ack,
  // 2 = sync termination, 3 = alternate 16/32, 4 = both acks
  always @(negedge clk) begin
    ack16 <= 1'b0; ack32 <= 1'b0; sterm <= 1'b0;
    if (bus_cyc && !rst) begin
      if (wcnt >= (ncyc % 2)) begin
        logic narrow;
        narrow = (mode == 0) || (mode == 3 && (ncyc % 2) == 0);
        if (ncyc < 8) begin
          log_addr[ncyc] = bus_addr;
          log_size[ncyc] = bus_size;
          log_t[ncyc]    = tcnt;
        end
        if (narrow) begin
          ack16 <= 1'b1;
          bus_rdata <= {mb({bus_addr[31:1], 1'b0}), mb({bus_addr[31:1], 1'b1}), 16'hC3A5};
        end else begin
          if (mode == 2) sterm <= 1'b1;
          else ack32 <= 1'b1;
          if (mode == 4) ack16 <= 1'b1;
          bus_rdata <= ml({bus_addr[31:2], 2'b00});
        end
        ncyc++;
        wcnt = 0;
      end else wcnt++;
    end else wcnt = 0;
  end

  always @(negedge clk) begin
    if (op_valid) begin op_got = op_data; op_t = tcnt; nop++; end
    if (fill_we) begin
      if (nfill < 4) begin fa[nfill] = fill_addr; fd[nfill] = fill_data; end
      nfill++;
    end
    if (busy_prev && !busy) idle_t = tcnt;
    busy_prev = busy;
  end

  task automatic run_op(logic [31:0] addr, int md, bit poke);
    logic [31:0] e, ea[4];
    logic [1:0]  es[4];
    int o, n, opc, t;
    @(negedge clk);
    mode = md; ncyc = 0; nop = 0; nfill = 0;
    e = {addr[31:2], 2'b00};
    o = int'(addr[1:0]);
    req_valid <= 1'b1; req_addr <= addr;
    @(negedge clk);
    req_valid <= 1'b0;
    // R1: first cycle at operand address, four bytes
    chk(bus_cyc && busy && bus_addr == addr && bus_size == 2'b00, "R1", "first cycle addr", bus_addr, addr);
    if (poke) begin
      // R9: a request presented while busy must be ignored
      req_valid <= 1'b1; req_addr <= addr + 32'h40;
      @(negedge clk); @(negedge clk);
      req_valid <= 1'b0;
    end
    t = 0;
    while (busy && t < 200) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    // expected order, computed from the requirements
    if (md == 0 || md == 3) begin
      n = (o == 0) ? 2 : 4;
      ea[0] = addr;
      ea[1] = (o == 0 || o == 1) ? e + 2 : e;
      ea[2] = e + 4; ea[3] = e + 6;
      es[0] = 2'b00; es[1] = 2'b10; es[3] = 2'b10;
      es[2] = (md == 3) ? 2'b00 : 2'b10;
      opc = (o == 0) ? 1 : (o == 3 ? 3 : 2);
    end else begin
      n = (o == 0) ? 1 : 2;
      ea[0] = addr; ea[1] = e + 4; ea[2] = '0; ea[3] = '0;
      es[0] = 2'b00; es[1] = 2'b00; es[2] = 2'b00; es[3] = 2'b00;
      opc = n - 1;
    end
    chk(ncyc == n, (md == 0) ? "R4" : (md == 2 ? "R3" : (md == 4 ? "R10" : "R2")),
        "cycle count", ncyc, n);
    for (int i = 0; i < n && i < ncyc; i++) begin
      chk(log_addr[i] == ea[i], (o == 0) ? "R5" : (md == 0 ? "R4" : "R2"), "cycle address", log_addr[i], ea[i]);
      chk(log_size[i] == es[i], (md == 3) ? "R10" : "R4", "cycle size", {30'b0, log_size[i]}, {30'b0, es[i]});
    end
    // R7 / R6: operand value, single pulse, timing
    chk(nop == 1, "R7", "op pulse count", nop, 1);
    chk(op_got == ml(addr), "R6", "operand data", op_got, ml(addr));
    if (opc < ncyc) chk(op_t == log_t[opc] + 1, "R7", "op timing", op_t, log_t[opc] + 1);
    // R8: fills
    chk(nfill == ((o == 0) ? 1 : 2), "R8", "fill count", nfill, (o == 0) ? 1 : 2);
    chk(fa[0] == e && fd[0] == ml(e), "R8", "fill entry0", fd[0], ml(e));
    if (o != 0) chk(fa[1] == e + 4 && fd[1] == ml(e + 4), "R8", "fill entry1", fd[1], ml(e + 4));
    // R9: busy drops after final termination, nothing follows
    if (ncyc >= 1 && ncyc <= 8) chk(idle_t == log_t[ncyc-1] + 1, "R9", "busy fall", idle_t, log_t[ncyc-1] + 1);
    chk(!bus_cyc && !busy, "R9", "idle after", {31'b0, bus_cyc}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk(!busy && !bus_cyc && !op_valid && !fill_we, "R9", "reset state", {28'b0, busy, bus_cyc, op_valid, fill_we}, 0);
    foreach (fa[i]) begin fa[i] = '0; fd[i] = '0; end
    for (int b = 0; b < 3; b++) begin
      for (int md = 0; md < 5; md++) begin
        for (int o = 0; o < 4; o++) begin
          logic [31:0] base;
          base = (b == 0) ? 32'h0000_0100 : (b == 1 ? 32'h1234_5670 : 32'h0000_FFF8);
          run_op(base + o, md, 1'b0);
        end
      end
    end
    run_op(32'h0000_0006, 0, 1'b1);
    run_op(32'h0000_0203, 1, 1'b1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule